// File: doc/BRIEF.md
# Pipelined Eight-Point Integer Inverse DCT

This block computes a one-dimensional eight-point inverse discrete cosine transform on signed two's complement integers. Each transfer carries a full vector of eight coefficients. Once the pipeline is full, it accepts one vector per clock and returns eight spatial samples a fixed number of cycles later. Transposition storage and the second pass of a two-dimensional transform are left to the surrounding logic.

The arithmetic runs in four steps, each with its own rounding:
- Constant rotations of coefficient pairs.
- An even/odd butterfly.
- A two-cycle odd-part scaling by the cosine-of-pi-quarter constant. Delay lines hold the remaining terms for these two cycles so they stay aligned.
- A final add/subtract that writes the eight samples in a fixed permuted order.

Every rounding step adds half of the last kept bit and then shifts right arithmetically. The coefficient constants are parameters. Internal arithmetic is 48 bits wide, so IN_W must not exceed 20.

Both the input side and the output side use a valid/ready handshake, and the whole pipeline advances as one unit. The pipeline advances when the output register is empty or the consumer takes its contents (`out_ready` high). When `out_valid` is high and `out_ready` is low, every stage holds its contents, `out_samp` stays unchanged and `in_ready` is low. A vector is transferred on a rising edge only when both `in_valid` and `in_ready` are high. A source with an unaccepted vector keeps `in_valid` and `in_coef` steady until the vector is taken.

Top module: `idct8_pipe`

## Requirements
- R1: During and right after synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: First step. Coefficient k sits at `in_coef[k*IN_W +: IN_W]`. Define `rs(v,s) = (v + 2^(s-1)) >>> s`. The first-step terms are:
  - a0 = rs((x0+x4)·C4, 9)
  - a1 = rs((x0−x4)·C4, 9)
  - a2 = rs(x2·C6 − x6·C2, 9)
  - a3 = rs(x2·C2 + x6·C6, 9)
  - a4 = rs(x1·C1 + x7·C7, 9)
  - a5 = rs(x1·C7 − x7·C1, 9)
  - a6 = rs(x3·C3 + x5·C5, 9)
  - a7 = rs(x3·C5 − x5·C3, 9)
  
  The default constants are C1..C7 = 4017, 3784, 3406, 2896, 2276, 1567, 799.
- R3: Second step:
  - b0 = rs(a0+a3, 2), b1 = rs(a1+a2, 2), b2 = rs(a1−a2, 2), b3 = rs(a0−a3, 2)
  - d0 = rs(a4+a6, 2), d1 = rs(a5+a7, 1), d2 = rs(a4−a6, 1), d3 = rs(a5−a7, 2)
- R4: Odd scaling: r0 = rs(rs(d1+d2, 1)·C4, 14) and r1 = rs(rs(d1−d2, 1)·C4, 14).
- R5: Output k sits at `out_samp[k*(IN_W+2) +: IN_W+2]`. Each output is rs(·, 3) of the following:
  - y0 = b0+d0, y1 = b1+r0, y5 = b2+r1, y3 = b3+d3
  - y7 = b0−d0, y6 = b1−r0, y2 = b2−r1, y4 = b3−d3
- R6: With `out_ready` held high, a vector accepted on a rising edge appears with `out_valid` high after the fifth rising edge, counting the accepting edge. A new vector can be accepted on every edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_samp` keep their values at the next edge.
- R8: Under any pattern of `in_valid` and `out_ready`, results leave in acceptance order, with none lost and none duplicated.
- R9: Inputs across the full IN_W range, including all-maximum and all-minimum vectors, produce exact R5 results in the IN_W+2 bit output with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Coefficient vector present |
| in_ready | output | 1 | Pipeline can take a vector |
| in_coef | input | 8*IN_W | Eight signed coefficients, index k at bits k*IN_W |
| out_valid | output | 1 | Sample vector present |
| out_ready | input | 1 | Consumer takes the sample vector |
| out_samp | output | 8*(IN_W+2) | Eight signed samples, index k at bits k*(IN_W+2) |

## Verification
With `out_ready` high, a result is due with `out_valid` after the fifth rising edge, counting the edge that accepted its vector. Stalls push that point back by one edge for each cycle the output is held. The bench drives inputs on the falling edge and judges each handshake just before the next rising edge. A reference queue matches every transfer out against the vector that was accepted in the same position. A separate directed measurement counts edges from one accepted vector to `out_valid` on an empty pipeline. While the output is stalled, the bench compares the held samples against those seen one cycle earlier.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
  localparam int ACC_W = 48;
  typedef logic signed [ACC_W-1:0] acc_t;

  // add half an LSB of the kept part, then arithmetic shift
  function automatic acc_t rnd_sh(input acc_t v, input int unsigned sh);
    return (v + (acc_t'(1) <<< (sh - 1))) >>> sh;
  endfunction
endpackage

// File: rtl/idct8_delay.sv
module idct8_delay #(
  parameter int W     = 48,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk) begin
        if (en) begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/idct8_front.sv
module idct8_front
  import idct8_pkg::*;
#(
  parameter int IN_W = 14,
  parameter int C1 = 4017, parameter int C2 = 3784, parameter int C3 = 3406,
  parameter int C4 = 2896, parameter int C5 = 2276, parameter int C6 = 1567,
  parameter int C7 = 799
) (
  input  logic              clk,
  input  logic              en,
  input  logic [8*IN_W-1:0] x_flat,
  output acc_t              a [8]
);
  localparam acc_t K1 = acc_t'(C1), K2 = acc_t'(C2), K3 = acc_t'(C3), K4 = acc_t'(C4);
  localparam acc_t K5 = acc_t'(C5), K6 = acc_t'(C6), K7 = acc_t'(C7);

  acc_t x [8];
  generate
    for (genvar k = 0; k < 8; k++) begin : g_ext
      assign x[k] = acc_t'($signed(x_flat[k*IN_W +: IN_W]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (en) begin
      a[0] <= rnd_sh((x[0] + x[4]) * K4, 9);
      a[1] <= rnd_sh((x[0] - x[4]) * K4, 9);
      a[2] <= rnd_sh(x[2] * K6 - x[6] * K2, 9);
      a[3] <= rnd_sh(x[2] * K2 + x[6] * K6, 9);
      a[4] <= rnd_sh(x[1] * K1 + x[7] * K7, 9);
      a[5] <= rnd_sh(x[1] * K7 - x[7] * K1, 9);
      a[6] <= rnd_sh(x[3] * K3 + x[5] * K5, 9);
      a[7] <= rnd_sh(x[3] * K5 - x[5] * K3, 9);
    end
  end
endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
  import idct8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  acc_t a [8],
  output acc_t b [4],
  output acc_t d [4]
);
  always_ff @(posedge clk) begin
    if (en) begin
      b[0] <= rnd_sh(a[0] + a[3], 2);
      b[1] <= rnd_sh(a[1] + a[2], 2);
      b[2] <= rnd_sh(a[1] - a[2], 2);
      b[3] <= rnd_sh(a[0] - a[3], 2);
      d[0] <= rnd_sh(a[4] + a[6], 2);
      d[1] <= rnd_sh(a[5] + a[7], 1);
      d[2] <= rnd_sh(a[4] - a[6], 1);
      d[3] <= rnd_sh(a[5] - a[7], 2);
    end
  end

  // the outer even pair together carries half of a0, within rounding slack
  AST_EVEN_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((b[0] + b[3] - ($past(a[0]) >>> 1)) >= -acc_t'(1)) &&
           ((b[0] + b[3] - ($past(a[0]) >>> 1)) <= acc_t'(2))); // R3
endmodule

// File: rtl/idct8_rotate.sv
module idct8_rotate
  import idct8_pkg::*;
#(
  parameter int C4 = 2896
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  acc_t d1,
  input  acc_t d2,
  output acc_t r0,
  output acc_t r1
);
  localparam acc_t K4 = acc_t'(C4);
  acc_t h0, h1;

  always_ff @(posedge clk) begin
    if (en) begin
      h0 <= rnd_sh(d1 + d2, 1);
      h1 <= rnd_sh(d1 - d2, 1);
      r0 <= rnd_sh(h0 * K4, 14);
      r1 <= rnd_sh(h1 * K4, 14);
    end
  end

  // scaling by a constant below 2^14 never grows the magnitude beyond one LSB
  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((r0 < 0 ? -r0 : r0) <= (($past(h0) < 0 ? -$past(h0) : $past(h0)) + acc_t'(1)))); // R4
endmodule

// File: rtl/idct8_pipe.sv
module idct8_pipe
  import idct8_pkg::*;
#(
  parameter int IN_W = 14,
  parameter int C1 = 4017, parameter int C2 = 3784, parameter int C3 = 3406,
  parameter int C4 = 2896, parameter int C5 = 2276, parameter int C6 = 1567,
  parameter int C7 = 799
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [8*IN_W-1:0]     in_coef,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [8*(IN_W+2)-1:0] out_samp
);
  localparam int OUT_W     = IN_W + 2;
  localparam int ROT_LAT   = 2;
  localparam int TOTAL_LAT = 1 + 1 + ROT_LAT + 1;

  logic adv;
  logic [TOTAL_LAT-1:0] vld;
  acc_t a [8];
  acc_t b [4];
  acc_t d [4];
  acc_t r0, r1;
  acc_t skew_in [6];
  acc_t late [6];
  logic [OUT_W-1:0] y [8];

  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;
  assign out_valid = vld[TOTAL_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[TOTAL_LAT-2:0], in_valid};
  end

  idct8_front #(.IN_W(IN_W), .C1(C1), .C2(C2), .C3(C3), .C4(C4), .C5(C5), .C6(C6), .C7(C7))
    u_front (.clk(clk), .en(adv), .x_flat(in_coef), .a(a));

  idct8_butterfly u_bfly (.clk(clk), .rst_n(rst_n), .en(adv), .a(a), .b(b), .d(d));

  idct8_rotate #(.C4(C4)) u_rot (.clk(clk), .rst_n(rst_n), .en(adv),
    .d1(d[1]), .d2(d[2]), .r0(r0), .r1(r1));

  // terms that bypass the odd scaling wait for it here
  assign skew_in[0] = b[0];
  assign skew_in[1] = b[1];
  assign skew_in[2] = b[2];
  assign skew_in[3] = b[3];
  assign skew_in[4] = d[0];
  assign skew_in[5] = d[3];

  generate
    for (genvar g = 0; g < 6; g++) begin : g_skew
      idct8_delay #(.W(ACC_W), .DEPTH(ROT_LAT)) u_dly (
        .clk(clk), .en(adv), .d(skew_in[g]), .q(late[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (adv) begin
      y[0] <= OUT_W'(rnd_sh(late[0] + late[4], 3));
      y[7] <= OUT_W'(rnd_sh(late[0] - late[4], 3));
      y[1] <= OUT_W'(rnd_sh(late[1] + r0, 3));
      y[6] <= OUT_W'(rnd_sh(late[1] - r0, 3));
      y[5] <= OUT_W'(rnd_sh(late[2] + r1, 3));
      y[2] <= OUT_W'(rnd_sh(late[2] - r1, 3));
      y[3] <= OUT_W'(rnd_sh(late[3] + late[5], 3));
      y[4] <= OUT_W'(rnd_sh(late[3] - late[5], 3));
    end
  end

  generate
    for (genvar k = 0; k < 8; k++) begin : g_out
      assign out_samp[k*OUT_W +: OUT_W] = y[k];
    end
  endgenerate

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_samp))); // R7
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
endmodule

// File: tb/tb_idct8_pipe.sv
module tb_idct8_pipe;
  localparam int IN_W  = 14;
  localparam int OUT_W = IN_W + 2;
  localparam longint C1 = 4017, C2 = 3784, C3 = 3406, C4 = 2896, C5 = 2276, C6 = 1567, C7 = 799;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [8*IN_W-1:0] in_coef = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [8*OUT_W-1:0] out_samp;

  int errors = 0;
  int checks = 0;
  longint expq [0:1023][0:7];
  string  tagq [0:1023];
  int wp = 0, rp = 0;
  string cur_tag = "R2 R3 R4 R5";
  bit bp_mode = 0;
  bit stall_prev = 0;
  logic [8*OUT_W-1:0] held;

  always #2 clk = ~clk;

  idct8_pipe #(.IN_W(IN_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready), .out_samp(out_samp));

  function automatic longint rs(input longint v, input int s);
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  function automatic longint ref_out(input logic [8*IN_W-1:0] v, input int k);
    longint x [8];
    longint a [8];
    longint b0, b1, b2, b3, d0, d1, d2, d3, r0, r1;
    for (int i = 0; i < 8; i++) x[i] = longint'($signed(v[i*IN_W +: IN_W]));
    a[0] = rs((x[0] + x[4]) * C4, 9);
    a[1] = rs((x[0] - x[4]) * C4, 9);
    a[2] = rs(x[2] * C6 - x[6] * C2, 9);
    a[3] = rs(x[2] * C2 + x[6] * C6, 9);
    a[4] = rs(x[1] * C1 + x[7] * C7, 9);
    a[5] = rs(x[1] * C7 - x[7] * C1, 9);
    a[6] = rs(x[3] * C3 + x[5] * C5, 9);
    a[7] = rs(x[3] * C5 - x[5] * C3, 9);
    b0 = rs(a[0] + a[3], 2); b1 = rs(a[1] + a[2], 2);
    b2 = rs(a[1] - a[2], 2); b3 = rs(a[0] - a[3], 2);
    d0 = rs(a[4] + a[6], 2); d1 = rs(a[5] + a[7], 1);
    d2 = rs(a[4] - a[6], 1); d3 = rs(a[5] - a[7], 2);
    r0 = rs(rs(d1 + d2, 1) * C4, 14);
    r1 = rs(rs(d1 - d2, 1) * C4, 14);
    case (k)
      0: return rs(b0 + d0, 3);
      1: return rs(b1 + r0, 3);
      2: return rs(b2 - r1, 3);
      3: return rs(b3 + d3, 3);
      4: return rs(b3 - d3, 3);
      5: return rs(b2 + r1, 3);
      6: return rs(b1 - r0, 3);
      default: return rs(b0 - d0, 3);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // evaluate the handshake just before the edge, then advance to the next falling edge
  task automatic step(output bit accepted);
    if (bp_mode) out_ready = ($urandom_range(0, 3) != 0);
    #1;
    if (stall_prev)
      check(out_valid && (out_samp == held), "R7 hold", longint'(out_valid), 1);
    if (out_valid && !out_ready) check(!in_ready, "R7 in_ready", longint'(in_ready), 0);
    stall_prev = out_valid && !out_ready;
    held = out_samp;
    accepted = in_valid && in_ready;
    if (accepted) begin
      for (int k = 0; k < 8; k++) expq[wp][k] = ref_out(in_coef, k);
      tagq[wp] = cur_tag;
      wp++;
    end
    if (out_valid && out_ready) begin
      if (rp >= wp) check(0, "R8 extra output", rp, wp);
      else begin
        int bad = -1;
        for (int k = 0; k < 8; k++)
          if (longint'($signed(out_samp[k*OUT_W +: OUT_W])) != expq[rp][k] && bad < 0) bad = k;
        if (bad < 0) check(1, tagq[rp], 0, 0);
        else check(0, $sformatf("%s R8 vec%0d idx%0d", tagq[rp], rp, bad),
                   longint'($signed(out_samp[bad*OUT_W +: OUT_W])), expq[rp][bad]);
        rp++;
      end
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [8*IN_W-1:0] v);
    bit acc;
    in_valid = 1;
    in_coef = v;
    do step(acc); while (!acc);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(acc);
  endtask

  function automatic logic [8*IN_W-1:0] fill(input int v);
    logic [8*IN_W-1:0] r;
    for (int k = 0; k < 8; k++) r[k*IN_W +: IN_W] = IN_W'(v);
    return r;
  endfunction

  function automatic logic [8*IN_W-1:0] rnd_vec();
    logic [8*IN_W-1:0] r;
    for (int k = 0; k < 8; k++) r[k*IN_W +: IN_W] = IN_W'($urandom_range(0, (1 << IN_W) - 1));
    return r;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8*IN_W-1:0] v;
    bit acc;
    int k;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R1 during reset", longint'({out_valid, in_ready}), 1);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(!out_valid && in_ready, "R1 after reset", longint'({out_valid, in_ready}), 1);
    @(negedge clk);

    // R6: latency from one accepted vector on an empty pipeline
    cur_tag = "R6 R5";
    in_valid = 1; in_coef = fill(100);
    step(acc);
    in_valid = 0;
    k = 1;
    while (!out_valid && k < 20) begin step(acc); k++; end
    check(k == 5, "R6 latency", k, 5);
    idle(4);

    // directed vectors: R2 R3 R4 R5 with permuted output positions
    cur_tag = "R2 R3 R4 R5 zero";
    send('0);
    cur_tag = "R2 R3 R4 R5 dc";
    v = '0; v[0 +: IN_W] = IN_W'(8191); send(v);
    for (int j = 1; j < 8; j++) begin
      cur_tag = $sformatf("R2 R3 R4 R5 impulse%0d", j);
      v = '0; v[j*IN_W +: IN_W] = IN_W'(1000); send(v);
      v = '0; v[j*IN_W +: IN_W] = IN_W'(-3); send(v);
    end
    // R9 full-range corners
    cur_tag = "R9 all max";   send(fill(8191));
    cur_tag = "R9 all min";   send(fill(-8192));
    cur_tag = "R9 alternating";
    for (int j = 0; j < 8; j++) v[j*IN_W +: IN_W] = (j % 2 == 0) ? IN_W'(8191) : IN_W'(-8192);
    send(v);
    for (int j = 0; j < 8; j++) v[j*IN_W +: IN_W] = ((j / 2) % 2 == 0) ? IN_W'(-8192) : IN_W'(8191);
    send(v);
    idle(6);

    // back-to-back random stream at full rate: R6 throughput
    cur_tag = "R6 R2 R3 R4 R5 stream";
    in_valid = 1;
    for (int j = 0; j < 300; j++) begin
      in_coef = rnd_vec();
      step(acc);
      check(acc, "R6 accept every cycle", longint'(acc), 1);
    end
    in_valid = 0;
    idle(6);

    // random valid and back-pressure: R7 R8
    cur_tag = "R8 R7 random";
    bp_mode = 1;
    for (int j = 0; j < 400; j++) begin
      if ($urandom_range(0, 9) < 7) send(rnd_vec());
      else idle(1);
    end
    bp_mode = 0;
    out_ready = 1;
    k = 0;
    while (rp < wp && k < 100) begin idle(1); k++; end
    idle(3);
    check(rp == wp, "R8 all results delivered", rp, wp);
    check(!out_valid, "R8 no stray output", longint'(out_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule